// File: doc/BRIEF.md
# Indexed-Word Multiply Unit

This unit computes one product per call. A caller presents a signed 32-bit scale factor, a byte base address and a signed 32-bit element index. It raises a start request. Once the call is taken, the unit forms the address of the indexed 32-bit word and issues one read on a memory-mapped read port. It multiplies the returned word by the scale factor and presents the low 32 bits of the product on its result bus.

Flow control works on both sides. Upstream, a call is taken only in a cycle where start is high and busy is low. Busy then stays high until the result has left the unit. Downstream, the unit raises done with the result. If the consumer holds stall high, done and the result stay frozen until stall drops. The memory answers with a fixed latency of one cycle and never stalls the read.

Top module: `idxmul_core`

## Requirements
- R1: While reset is high, and in the cycle after it is released, busy, done and mem_read are low and result is zero.
- R2: A call is accepted on a clock edge where start is high and busy is low. Busy is high in the cycle after acceptance.
- R3: Each call issues exactly one single-cycle read. The read uses mem_addr = base + index*4, where index is sign-extended and the sum wraps to ADDR_W bits. mem_byteen is all ones (4'b1111) while mem_read is high.
- R4: mem_rdata is taken in the cycle right after the cycle in which mem_read is high, which is the fixed one-cycle read latency.
- R5: result equals the low 32 bits of the signed product of the scale argument and the fetched word, wrapping on overflow.
- R6: While done is high and stall is high, done stays high and result does not change on the next edge.
- R7: Busy stays high from acceptance through the edge where done is high and stall is low. In the cycle after that edge, both busy and done are low.
- R8: Done first rises in the third cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Call request from the caller |
| busy | output | 1 | Unit occupied; the caller holds start and the arguments |
| arg_scale | input | 32 | Signed scale factor |
| arg_base | input | ADDR_W | Byte base address of the word array |
| arg_index | input | 32 | Signed element index |
| done | output | 1 | Result valid |
| stall | input | 1 | Consumer back-pressure |
| result | output | 32 | Signed product, low 32 bits |
| mem_read | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read byte address |
| mem_byteen | output | 4 | Byte enables |
| mem_rdata | input | 32 | Read data, valid one cycle after mem_read |

## Verification
The bench builds the unit with ADDR_W at its default of 32. Negative indices therefore wrap the byte address over the full 32-bit space, and the bench checks that wrapped address exactly. The memory stub decodes 256 words from address bits 9:2. Outside the valid latency cycle the stub returns a junk word, so a wrong sampling cycle shows up as a wrong product. Overflowing products are mixed with stall patterns that range from none, to random, to long forced holds, to a reset in the middle of a call.

// File: rtl/idxmul_pkg.sv
package idxmul_pkg;

    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;

    typedef logic signed [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_CAPT = 2'd2,
        ST_DONE = 2'd3
    } call_state_e;

    typedef struct packed {
        logic accept;
        logic rd_issue;
        logic capture;
    } ctrl_strobes_t;

    function automatic word_t wrap_mul(input word_t a, input word_t b);
        logic signed [2*WORD_W-1:0] full;
        full = a * b;
        return full[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/idxmul_ctrl.sv
module idxmul_ctrl
    import idxmul_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stall,
    output logic          busy,
    output logic          done,
    output ctrl_strobes_t strobes
);

    call_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start) state_d = ST_READ;
            ST_READ: state_d = ST_CAPT;
            ST_CAPT: state_d = ST_DONE;
            ST_DONE: if (!stall) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign busy             = (state_q != ST_IDLE);
    assign done             = (state_q == ST_DONE);
    assign strobes.accept   = (state_q == ST_IDLE) && start;
    assign strobes.rd_issue = (state_q == ST_READ);
    assign strobes.capture  = (state_q == ST_CAPT);

endmodule

// File: rtl/idxmul_agen.sv
module idxmul_agen
    import idxmul_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] base,
    input  word_t             index,
    output logic [ADDR_W-1:0] addr
);

    localparam bit POW2   = (WORD_BYTES & (WORD_BYTES - 1)) == 0;
    localparam int SHIFT  = $clog2(WORD_BYTES);

    logic [ADDR_W-1:0] idx_ext;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] addr_q;

    assign idx_ext = ADDR_W'(index);

    generate
        if (POW2) begin : g_shift
            assign offset = idx_ext << SHIFT;
        end else begin : g_mult
            assign offset = ADDR_W'(idx_ext * ADDR_W'(WORD_BYTES));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)         addr_q <= '0;
        else if (accept) addr_q <= base + offset;
    end

    assign addr = addr_q;

endmodule

// File: rtl/idxmul_mult.sv
module idxmul_mult
    import idxmul_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  logic  capture,
    input  word_t scale_in,
    input  word_t rdata,
    output word_t product
);

    word_t scale_q;
    word_t product_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scale_q   <= '0;
            product_q <= '0;
        end else begin
            if (accept)  scale_q   <= scale_in;
            if (capture) product_q <= wrap_mul(scale_q, rdata);
        end
    end

    assign product = product_q;

endmodule

// File: rtl/idxmul_core.sv
module idxmul_core
    import idxmul_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    output logic                  busy,
    input  logic [WORD_W-1:0]     arg_scale,
    input  logic [ADDR_W-1:0]     arg_base,
    input  logic [WORD_W-1:0]     arg_index,
    output logic                  done,
    input  logic                  stall,
    output logic [WORD_W-1:0]     result,
    output logic                  mem_read,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [WORD_BYTES-1:0] mem_byteen,
    input  logic [WORD_W-1:0]     mem_rdata
);

    ctrl_strobes_t strobes;
    word_t         product;

    idxmul_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .stall   (stall),
        .busy    (busy),
        .done    (done),
        .strobes (strobes)
    );

    idxmul_agen #(.ADDR_W(ADDR_W)) u_agen (
        .clk    (clk),
        .rst    (rst),
        .accept (strobes.accept),
        .base   (arg_base),
        .index  (word_t'(arg_index)),
        .addr   (mem_addr)
    );

    idxmul_mult u_mult (
        .clk      (clk),
        .rst      (rst),
        .accept   (strobes.accept),
        .capture  (strobes.capture),
        .scale_in (word_t'(arg_scale)),
        .rdata    (word_t'(mem_rdata)),
        .product  (product)
    );

    assign mem_read   = strobes.rd_issue;
    assign mem_byteen = '1;
    assign result     = product;

endmodule

// File: rtl/idxmul_core_chk.sv
module idxmul_core_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              stall,
    input logic [31:0]       result,
    input logic              mem_read,
    input logic [3:0]        mem_byteen,
    input logic [ADDR_W-1:0] mem_addr
);

    logic past_rst = 1'b0;
    always_ff @(posedge clk) past_rst <= rst;

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        past_rst |-> (!busy && !done && !mem_read && result == 32'd0));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R3
    single_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_read |=> !mem_read);

    // R3
    byteen_full_chk: assert property (@(posedge clk) disable iff (rst)
        mem_read |-> (mem_byteen == 4'b1111));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && stall) |=> (done && $stable(result)));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !(done && !stall)) |=> busy);

    // R7
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !stall) |=> (!done && !busy));

    // R7
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

endmodule

bind idxmul_core idxmul_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .stall      (stall),
    .result     (result),
    .mem_read   (mem_read),
    .mem_byteen (mem_byteen),
    .mem_addr   (mem_addr)
);

// File: tb/idxmul_core_tb.sv
module idxmul_core_tb;

    localparam int ADDR_W = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        stall = 1'b0;
    logic [31:0] arg_scale = '0;
    logic [31:0] arg_base = '0;
    logic [31:0] arg_index = '0;
    logic        busy, done, mem_read;
    logic [31:0] result, mem_addr;
    logic [3:0]  mem_byteen;
    logic [31:0] mem_rdata = 32'hDEAD_BEEF;

    int checks = 0;
    int failures = 0;

    logic [31:0] mem [256];
    int          read_count = 0;
    logic [31:0] last_addr = '0;
    logic [3:0]  last_be = '0;

    always #5 clk = ~clk;

    idxmul_core #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy),
        .arg_scale(arg_scale), .arg_base(arg_base), .arg_index(arg_index),
        .done(done), .stall(stall), .result(result),
        .mem_read(mem_read), .mem_addr(mem_addr), .mem_byteen(mem_byteen),
        .mem_rdata(mem_rdata)
    );

    // memory stub: one-cycle latency, junk outside the valid cycle
    always @(posedge clk) begin
        if (mem_read) begin
            mem_rdata  <= mem[mem_addr[9:2]];
            read_count <= read_count + 1;
            last_addr  <= mem_addr;
            last_be    <= mem_byteen;
        end else begin
            mem_rdata  <= $urandom;
        end
    end

    function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [31:0] i);
        return b + (i << 2);
    endfunction

    function automatic logic [31:0] exp_prod(input logic [31:0] a, input logic [31:0] w);
        logic signed [63:0] p;
        p = $signed(a) * $signed(w);
        return p[31:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_call(input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] i, input int force_stall, input int pct);
        logic [31:0] ea, ep, held;
        int          rc0, cyc, left;
        bit          seen;
        ea   = exp_addr(b, i);
        ep   = exp_prod(a, mem[ea[9:2]]);
        rc0  = read_count;
        seen = 0;
        left = force_stall;
        held = '0;
        @(negedge clk);
        start = 1'b1; arg_scale = a; arg_base = b; arg_index = i;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after accept", 32'(busy), 32'd1);
        cyc = 1;
        while (cyc < 60) begin
            if (done) begin
                if (!seen) begin
                    check(cyc == 3, "R8 done latency", 32'(cyc), 32'd3);
                    check(result == ep, "R5/R4 product", result, ep);
                    check(read_count - rc0 == 1, "R3 read count", 32'(read_count - rc0), 32'd1);
                    check(last_addr == ea, "R3 address", last_addr, ea);
                    check(last_be == 4'hF, "R3 byte enables", 32'(last_be), 32'hF);
                    seen = 1;
                    held = result;
                end else begin
                    check(result == held, "R6 result held", result, held);
                end
            end
            if (done && left > 0) begin
                stall = 1'b1;
                left--;
            end else begin
                stall = ($urandom_range(99) < pct);
            end
            if (done && !stall) begin
                @(negedge clk);
                check(!done, "R7 done released", 32'(done), 32'd0);
                check(!busy, "R7 busy released", 32'(busy), 32'd0);
                stall = 1'b0;
                break;
            end
            if (done && stall) begin
                @(negedge clk);
                cyc++;
                check(done, "R6 done held under stall", 32'(done), 32'd1);
                continue;
            end
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 60) check(1'b0, "R7 call never completed", 32'(cyc), 32'd0);
        stall = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int k = 0; k < 256; k++) mem[k] = $urandom;
        mem[10] = 32'h7FFF_FFFF;
        mem[11] = 32'h8000_0000;
        mem[12] = 32'hFFFF_FFFF;

        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_read, "R1 idle in reset", {busy, done, mem_read}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mem_read, "R1 idle after reset", {busy, done, mem_read}, 0);
        check(result == 32'd0, "R1 result zero", result, 32'd0);

        // directed corners
        do_call(32'd2, 32'h0000_0000, 32'd10, 0, 0);           // wrap positive overflow
        do_call(32'hFFFF_FFFF, 32'h0000_0010, 32'd7, 0, 0);    // -1 * min
        do_call(32'hFFFF_FFFD, 32'h0000_0030, 32'd0, 0, 0);    // index zero, neg*neg
        do_call(32'd12345, 32'h0000_0100, 32'hFFFF_FFF0, 0, 0); // negative index
        do_call(32'h8000_0000, 32'hFFFF_FFF0, 32'd8, 0, 0);    // base wraps address
        do_call(32'd77, 32'h0000_0200, 32'd5, 9, 0);           // long forced stall

        // random calls with random stall
        for (int n = 0; n < 150; n++) begin
            logic [31:0] a, b, i;
            a = $urandom;
            b = {$urandom_range(255), 2'b00};
            i = $urandom_range(600) - 300;
            do_call(a, b, i, $urandom_range(3), 40);
        end

        // reset in the middle of a call
        @(negedge clk);
        start = 1'b1; arg_scale = 32'd3; arg_base = '0; arg_index = 32'd1;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mem_read, "R1 idle after mid-call reset",
              {busy, done, mem_read}, 0);
        check(result == 32'd0, "R1 result cleared", result, 32'd0);
        do_call(32'd9, 32'h0000_0040, 32'd3, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule